// File: doc/BRIEF.md
# Transmit Completion Ring Writer

This block reports finished transmit packets to the host through a circular ring of result entries held in shared memory. When a packet finishes, a completion event arrives with the packet's request flags, its id, a status byte, a retry count and two timing values. The timing values are computed elsewhere. If the packet asked for a completion report, the block serialises a result entry into the next ring slot, one byte per cycle, over a byte-wide memory write port. It then hands the slot to the host and may raise an interrupt.

Each entry carries two ownership marks, one in its first byte and one in its last byte. The first mark is written first and the second mark is written last. The host therefore treats a slot as ready only when both marks read 1, and it never acts on a partly written entry. After reading a slot, the host clears both marks in memory and reports the slot number on the release path. The block tracks which slots the host owns. It stalls the event input rather than overwrite a slot the host still holds.

The interrupt line is a level output. It has two modes: it can rise for every reported packet, or it can rise once the number of host-owned results reaches a programmable threshold. In both modes it stays high until the host acknowledges it.

Top module: `tx_done_ring_writer`

## Requirements
- R1: After reset, `irq` and `memWe` are 0, `evReady` is 1, and the first entry written goes to slot 0.
- R2: An event whose flag byte has bit 7 (value 0x80) clear is accepted but writes nothing. It does not raise `irq` and does not advance the slot pointer.
- R3: An event with bit 7 set produces 8 writes in consecutive cycles. They start the cycle after acceptance, at addresses slot*8+0 through slot*8+7, in rising order. Byte 0 is the first mark (0x01), byte 1 is the id, byte 2 the status, byte 3 the retry count, bytes 4 and 5 the airtime (low byte first), byte 6 the delay, and byte 7 the second mark (0x01).
- R4: Reported entries take slots 0,1,…,15 in order and then wrap back to slot 0.
- R5: The status byte is copied without change. The value 0 means success; bit 7 means DMA error, bit 6 disabled, bit 5 retry limit exceeded, bit 4 timeout, bit 3 key not found, bit 2 encryption failure and bit 1 unavailable priority.
- R6: `evReady` is 0 during all cycles in which an entry is being written.
- R7: While the next slot is host-owned, `evReady` is 0 and no write occurs.
- R8: A release names one slot and frees only that slot. Releasing a slot other than the next slot leaves the input stalled.
- R9: With `aggMode`=0, `irq` goes to 1 on the same clock edge that writes the second mark of each entry.
- R10: With `aggMode`=1, `irq` is raised only when an entry completes and the number of host-owned slots is then at or above the threshold.
- R11: A threshold of 0 acts as 1, and a threshold above 16 acts as 16.
- R12: `irq` stays high until `irqAck` is sampled high. If `irqAck` is high in the same cycle as a new interrupt cause, `irq` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evValid | input | 1 | Completion event present |
| evReady | output | 1 | Event accepted at this edge when valid |
| evFlags | input | 8 | Request flags; bit 7 asks for a report |
| evId | input | 8 | Packet id from the transmit descriptor |
| evStatus | input | 8 | Result status bits |
| evRetries | input | 8 | Retry count |
| evAirtime | input | 16 | Air time used |
| evDelay | input | 8 | Queue delay |
| relValid | input | 1 | Host has cleared a slot |
| relSlot | input | 4 | Slot the host cleared |
| aggMode | input | 1 | 0: interrupt per packet; 1: threshold mode |
| aggThresh | input | 5 | Pending-count threshold |
| irqAck | input | 1 | Clears the interrupt |
| irq | output | 1 | Level interrupt to the host |
| memWe | output | 1 | Ring byte write enable |
| memAddr | output | 7 | Ring byte address |
| memData | output | 8 | Ring byte data |

## Verification
The bench builds the block with its default ring of 16 slots and 8-byte entries. This keeps the full ring within a few hundred cycles. Filling every slot exercises the wrap from slot 15 back to slot 0 and the stall on a host-owned slot. It also reaches a threshold of exactly 16, so the clamp of oversize threshold values is checked at its real limit.

// File: rtl/tdrw_pkg.sv
package tdrw_pkg;
  localparam int RING_SLOTS  = 16;
  localparam int SLOT_W      = $clog2(RING_SLOTS);
  localparam int CNT_W       = SLOT_W + 1;
  localparam int ENTRY_BYTES = 8;
  localparam int BYTE_W      = $clog2(ENTRY_BYTES);
  localparam int ADDR_W      = SLOT_W + BYTE_W;
  localparam int REQ_BIT     = 7;
  localparam logic [7:0] DONE_MARK = 8'h01;

  // byte offsets inside one ring entry; the two marks bracket the entry
  localparam int OFS_MARK_A = 0;
  localparam int OFS_ID     = 1;
  localparam int OFS_STATUS = 2;
  localparam int OFS_RETRY  = 3;
  localparam int OFS_AIR_LO = 4;
  localparam int OFS_AIR_HI = 5;
  localparam int OFS_DELAY  = 6;
  localparam int OFS_MARK_B = ENTRY_BYTES - 1;

  typedef enum logic {ST_IDLE = 1'b0, ST_WRITE = 1'b1} wrState_t;

  typedef struct packed {
    logic              load;
    logic              we;
    logic [BYTE_W-1:0] byteSel;
    logic [SLOT_W-1:0] slot;
  } wrStrobe_t;
endpackage

// File: rtl/tdrw_ctrl.sv
module tdrw_ctrl
  import tdrw_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              evValid,
  input  logic              evReqFlag,
  input  logic              relValid,
  input  logic [SLOT_W-1:0] relSlot,
  input  logic              aggMode,
  input  logic [CNT_W-1:0]  aggThresh,
  input  logic              irqAck,
  output logic              evReady,
  output logic              irq,
  output wrStrobe_t         strobe
);
  wrState_t          state;
  logic [SLOT_W-1:0] wrPtr;
  logic [BYTE_W-1:0] byteIdx;
  logic [RING_SLOTS-1:0] owned;
  logic [CNT_W-1:0]  pendCnt;

  logic             accept, startWrite, finishWrite, relHit, irqSet;
  logic [CNT_W-1:0] thrEff, pendNext;

  always_comb begin
    evReady     = (state == ST_IDLE) && !owned[wrPtr];
    accept      = evValid && evReady;
    startWrite  = accept && evReqFlag;
    finishWrite = (state == ST_WRITE) && (byteIdx == BYTE_W'(ENTRY_BYTES - 1));
    relHit      = relValid && owned[relSlot];
    if (aggThresh == '0)
      thrEff = CNT_W'(1);
    else if (aggThresh > CNT_W'(RING_SLOTS))
      thrEff = CNT_W'(RING_SLOTS);
    else
      thrEff = aggThresh;
    pendNext = pendCnt + CNT_W'(finishWrite) - CNT_W'(relHit);
    irqSet   = finishWrite && (!aggMode || (pendNext >= thrEff));
    strobe.load    = startWrite;
    strobe.we      = (state == ST_WRITE);
    strobe.byteSel = byteIdx;
    strobe.slot    = wrPtr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      wrPtr   <= '0;
      byteIdx <= '0;
      owned   <= '0;
      pendCnt <= '0;
      irq     <= 1'b0;
    end else begin
      pendCnt <= pendNext;
      if (relHit) owned[relSlot] <= 1'b0;
      case (state)
        ST_IDLE: if (startWrite) begin
          state   <= ST_WRITE;
          byteIdx <= '0;
        end
        ST_WRITE: if (finishWrite) begin
          state        <= ST_IDLE;
          byteIdx      <= '0;
          owned[wrPtr] <= 1'b1;
          wrPtr        <= wrPtr + SLOT_W'(1);
        end else begin
          byteIdx <= byteIdx + BYTE_W'(1);
        end
        default: state <= ST_IDLE;
      endcase
      if (irqSet)      irq <= 1'b1;
      else if (irqAck) irq <= 1'b0;
    end
  end

  // R7: a slot is never completed while the host still owns it
  assert_no_overwrite_R7: assert property (@(posedge clk) disable iff (!rstN)
    finishWrite |-> !owned[wrPtr]);

  // R6: input held off while an entry is in flight
  assert_busy_stall_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.we |-> !evReady);

  // R4: the slot pointer only ever steps by one
  assert_ptr_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(wrPtr) |-> (wrPtr == $past(wrPtr) + SLOT_W'(1)));

  // R9: interrupt rises only on completion of an entry
  assert_irq_cause_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(finishWrite));

  // R12: level held until acknowledged
  assert_irq_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !irqAck) |=> irq);
endmodule

// File: rtl/tdrw_datapath.sv
module tdrw_datapath
  import tdrw_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  wrStrobe_t         strobe,
  input  logic [7:0]        evId,
  input  logic [7:0]        evStatus,
  input  logic [7:0]        evRetries,
  input  logic [15:0]       evAirtime,
  input  logic [7:0]        evDelay,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memData
);
  logic [7:0]  idReg, statusReg, retryReg, delayReg;
  logic [15:0] airReg;
  logic [7:0]  entryByte [ENTRY_BYTES];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idReg     <= '0;
      statusReg <= '0;
      retryReg  <= '0;
      delayReg  <= '0;
      airReg    <= '0;
    end else if (strobe.load) begin
      idReg     <= evId;
      statusReg <= evStatus;
      retryReg  <= evRetries;
      delayReg  <= evDelay;
      airReg    <= evAirtime;
    end
  end

  always_comb begin
    for (int i = 0; i < ENTRY_BYTES; i++) entryByte[i] = 8'h00;
    entryByte[OFS_MARK_A] = DONE_MARK;
    entryByte[OFS_ID]     = idReg;
    entryByte[OFS_STATUS] = statusReg;
    entryByte[OFS_RETRY]  = retryReg;
    entryByte[OFS_AIR_LO] = airReg[7:0];
    entryByte[OFS_AIR_HI] = airReg[15:8];
    entryByte[OFS_DELAY]  = delayReg;
    entryByte[OFS_MARK_B] = DONE_MARK;
  end

  assign memWe   = strobe.we;
  assign memAddr = {strobe.slot, strobe.byteSel};
  assign memData = entryByte[strobe.byteSel];

  // R3: an entry always opens with the first ownership mark
  assert_first_mark_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobe.we) |-> (strobe.byteSel == '0 && memData == DONE_MARK));

  // R3: captured fields do not move while the entry is written
  assert_fields_stable_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.we && $past(strobe.we)) |-> ($stable(idReg) && $stable(statusReg)));
endmodule

// File: rtl/tx_done_ring_writer.sv
module tx_done_ring_writer
  import tdrw_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              evValid,
  output logic              evReady,
  input  logic [7:0]        evFlags,
  input  logic [7:0]        evId,
  input  logic [7:0]        evStatus,
  input  logic [7:0]        evRetries,
  input  logic [15:0]       evAirtime,
  input  logic [7:0]        evDelay,
  input  logic              relValid,
  input  logic [SLOT_W-1:0] relSlot,
  input  logic              aggMode,
  input  logic [CNT_W-1:0]  aggThresh,
  input  logic              irqAck,
  output logic              irq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memData
);
  wrStrobe_t strobe;

  tdrw_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .evValid   (evValid),
    .evReqFlag (evFlags[REQ_BIT]),
    .relValid  (relValid),
    .relSlot   (relSlot),
    .aggMode   (aggMode),
    .aggThresh (aggThresh),
    .irqAck    (irqAck),
    .evReady   (evReady),
    .irq       (irq),
    .strobe    (strobe)
  );

  tdrw_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .evId      (evId),
    .evStatus  (evStatus),
    .evRetries (evRetries),
    .evAirtime (evAirtime),
    .evDelay   (evDelay),
    .memWe     (memWe),
    .memAddr   (memAddr),
    .memData   (memData)
  );
endmodule

// File: tb/tx_done_ring_writer_bench.sv
module tx_done_ring_writer_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic evValid = 1'b0;
  logic evReady;
  logic [7:0] evFlags = '0, evId = '0, evStatus = '0, evRetries = '0, evDelay = '0;
  logic [15:0] evAirtime = '0;
  logic relValid = 1'b0;
  logic [3:0] relSlot = '0;
  logic aggMode = 1'b0;
  logic [4:0] aggThresh = 5'd1;
  logic irqAck = 1'b0;
  logic irq, memWe;
  logic [6:0] memAddr;
  logic [7:0] memData;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [3:0] nextSlot = '0;

  always #2 clk = ~clk;

  tx_done_ring_writer u_tx_done_ring_writer (
    .clk(clk), .rstN(rstN), .evValid(evValid), .evReady(evReady),
    .evFlags(evFlags), .evId(evId), .evStatus(evStatus), .evRetries(evRetries),
    .evAirtime(evAirtime), .evDelay(evDelay), .relValid(relValid), .relSlot(relSlot),
    .aggMode(aggMode), .aggThresh(aggThresh), .irqAck(irqAck), .irq(irq),
    .memWe(memWe), .memAddr(memAddr), .memData(memData)
  );

  // {flags, id, status, retries, airtime, delay}
  localparam logic [55:0] VEC [6] = '{
    {8'h80, 8'h11, 8'h00, 8'h00, 16'h1234, 8'h05},
    {8'h80, 8'h22, 8'h80, 8'h03, 16'hABCD, 8'h7F},
    {8'h00, 8'h33, 8'h00, 8'h00, 16'h0000, 8'h00},
    {8'hFF, 8'h44, 8'h20, 8'h0F, 16'h00FF, 8'h10},
    {8'h7F, 8'h55, 8'h04, 8'h01, 16'h1111, 8'h22},
    {8'h80, 8'h66, 8'h02, 8'h07, 16'hFFFF, 8'hFF}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] expByte(input logic [55:0] v, input int b);
    case (b)
      0: expByte = 8'h01;
      1: expByte = v[47:40];
      2: expByte = v[39:32];
      3: expByte = v[31:24];
      4: expByte = v[15:8];
      5: expByte = v[23:16];
      6: expByte = v[7:0];
      default: expByte = 8'h01;
    endcase
  endfunction

  // returns at the falling edge after the completing clock edge
  task automatic sendAndCheck(input logic [55:0] v, input bit ackLast);
    @(negedge clk);
    {evFlags, evId, evStatus, evRetries, evAirtime, evDelay} = v;
    evValid = 1'b1;
    while (!evReady) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    evValid = 1'b0;
    if (v[55]) begin
      for (int b = 0; b < 8; b++) begin
        check("R3 write enable", memWe, 1);
        check("R3/R4 address", memAddr, {nextSlot, 3'(b)});
        check("R3/R5 entry byte", memData, expByte(v, b));
        check("R6 ready low while writing", evReady, 0);
        if (b == 7 && ackLast) irqAck = 1'b1;
        @(negedge clk);
      end
      check("R3 write ends after mark", memWe, 0);
      nextSlot = nextSlot + 4'd1;
    end else begin
      for (int c = 0; c < 9; c++) begin
        check("R2 no write for unrequested", memWe, 0);
        @(negedge clk);
      end
      check("R2 no irq for unrequested", irq, 0);
    end
  endtask

  task automatic releaseSlot(input logic [3:0] s);
    @(negedge clk);
    relValid = 1'b1;
    relSlot  = s;
    @(negedge clk);
    relValid = 1'b0;
  endtask

  task automatic ackIrq();
    @(negedge clk);
    irqAck = 1'b1;
    @(negedge clk);
    irqAck = 1'b0;
  endtask

  task automatic releaseAll();
    for (int s = 0; s < 16; s++) releaseSlot(4'(s));
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 irq after reset", irq, 0);
    check("R1 memWe after reset", memWe, 0);
    check("R1 ready after reset", evReady, 1);

    // table walk, per-packet interrupts (R1 first slot 0, R2, R3, R5, R9)
    for (int i = 0; i < 6; i++) begin
      sendAndCheck(VEC[i], 1'b0);
      if (VEC[i][55]) begin
        check("R9 irq per packet", irq, 1);
        ackIrq();
        check("R12 ack clears irq", irq, 0);
        releaseSlot(nextSlot - 4'd1);
      end
    end

    // R12: ack coincident with new cause keeps irq high
    sendAndCheck({8'h80, 8'h77, 8'h10, 8'h02, 16'h0102, 8'h03}, 1'b1);
    check("R12 set wins over ack", irq, 1);
    @(negedge clk);
    irqAck = 1'b0;
    check("R12 later ack clears", irq, 0);
    releaseAll();

    // R10: threshold 3
    aggMode = 1'b1;
    aggThresh = 5'd3;
    for (int k = 1; k <= 3; k++) begin
      sendAndCheck({8'h80, 8'(8'h80 + k), 8'h08, 8'h00, 16'h0042, 8'h01}, 1'b0);
      check("R10 threshold 3 irq", irq, (k == 3) ? 1 : 0);
    end
    ackIrq();
    releaseAll();

    // R11: threshold 0 acts as 1
    aggThresh = 5'd0;
    sendAndCheck({8'h80, 8'h90, 8'h40, 8'h00, 16'h0007, 8'h02}, 1'b0);
    check("R11 threshold 0 as 1", irq, 1);
    ackIrq();
    releaseAll();

    // R11: threshold 20 acts as 16; fill whole ring and wrap (R4)
    aggThresh = 5'd20;
    for (int k = 1; k <= 16; k++) begin
      sendAndCheck({8'h80, 8'(k), 8'h01, 8'(k), 16'(k * 3), 8'(k)}, 1'b0);
      check("R11 threshold above 16", irq, (k == 16) ? 1 : 0);
    end
    ackIrq();

    // R7: stall on host-owned next slot
    check("R7 ready low when ring full", evReady, 0);
    evFlags = 8'h80;
    evValid = 1'b1;
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      check("R7 no write while stalled", memWe, 0);
    end
    evValid = 1'b0;
    releaseSlot(nextSlot + 4'd5);
    check("R8 other slot release keeps stall", evReady, 0);
    releaseSlot(nextSlot);
    check("R8 next slot release unstalls", evReady, 1);
    sendAndCheck({8'h80, 8'hA5, 8'h00, 8'h09, 16'hBEEF, 8'h44}, 1'b0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule